// File: doc/BRIEF.md
# DRAM Reclock Command Sequencer

This block walks a DRAM device through a frequency change without losing its contents. On a start pulse it captures the memory kind and two sets of mode-register values: the values the device holds now and the values it must hold after the change. It then steps through a fixed order of operations. It can first switch the DLL off. It then parks the device in self-refresh, requests the clock change, brings the device back out and rewrites the mode registers that differ. It requests a timing-register update and, when the DLL stays enabled, runs a DLL reset and waits for lock.

Device commands appear on a one-hot strobe vector. A mode-register write carries its register index and data. The clock change and the timing update are requests that an outside block acknowledges. Every wait between steps is counted in clock cycles by one shared down-counter. Each wait length is a parameter, and the DLL lock time is chosen by memory kind. The sequencer ends with a one-cycle done pulse. An unsupported memory kind produces a one-cycle error pulse and no commands.

Top module: `dram_reclock_seq`

## Requirements
- R1: While reset is held and after its release, with no start pulse, every command strobe, both requests, done and error stay low.
- R2: A start with memory kind 3 (kinds are 0 DDR2, 1 DDR3, 2 GDDR3) raises error for exactly one cycle, in the cycle after the start is sampled, and issues no command or request.
- R3: The DLL-off bit is MR1 bit 0 for DDR2 and DDR3 and MR1 bit 6 for GDDR3. When the current MR1 has that bit clear and the target has it set, the first commands are a precharge and then an MR1 write of the current MR1 with the bit set. A write-recovery wait follows.
- R4: Self-refresh entry is precharge, refresh, refresh, auto-refresh off and self-refresh on, then the entry wait, then the clock-change request.
- R5: The clock-change request stays high until its acknowledge is sampled. The exit wait follows, then precharge, self-refresh off and auto-refresh on, then the exit-to-command wait.
- R6: Mode registers are then rewritten in the order 2, 1, 0. Each write uses the target value, happens only when target and current differ, and is followed by the write-recovery wait.
- R7: For DDR2 and GDDR3 the current MR2 input is ignored and MR2 is never written.
- R8: After the mode-register rewrites, the timing-update request is raised and held until its acknowledge is sampled.
- R9: When the target MR1 leaves the DLL enabled, MR0 is written with the target value with bit 8 set, then after the write-recovery wait with the target value unchanged. The next step follows after write recovery plus the lock time of the kind.
- R10: For GDDR3 a precharge follows the DLL reset.
- R11: Done is high for exactly one cycle, one cycle after the final step or wait completes.
- R12: A start pulse while a sequence runs is ignored, and input changes after the start have no effect on the sequence.
- R13: A step lasts one cycle, or until acknowledge for a request. A wait of N cycles delays the next step by N more cycles, so N = 0 adds nothing. The step after the start pulse comes one cycle after it.
- R14: Strobe bits are 0 precharge, 1 refresh, 2 mode-register write, 3 auto-refresh off, 4 auto-refresh on, 5 self-refresh on, 6 self-refresh off. At most one strobe or request is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| kind_i | input | 2 | Memory kind: 0 DDR2, 1 DDR3, 2 GDDR3, 3 unsupported |
| cur_mr0_i | input | MR_W | Current MR0 value |
| cur_mr1_i | input | MR_W | Current MR1 value |
| cur_mr2_i | input | MR_W | Current MR2 value (used for DDR3 only) |
| tgt_mr0_i | input | MR_W | Target MR0 value |
| tgt_mr1_i | input | MR_W | Target MR1 value |
| tgt_mr2_i | input | MR_W | Target MR2 value |
| clk_ack_i | input | 1 | Acknowledge of the clock-change request |
| tim_ack_i | input | 1 | Acknowledge of the timing-update request |
| cmd_o | output | 7 | One-hot device command strobe |
| mrs_idx_o | output | 2 | Mode-register index during a write |
| mrs_data_o | output | MR_W | Mode-register data during a write |
| clk_req_o | output | 1 | Clock-change request |
| tim_req_o | output | 1 | Timing-update request |
| done_o | output | 1 | Sequence finished, one-cycle pulse |
| err_o | output | 1 | Unsupported kind, one-cycle pulse |

## Verification
A wrong step register shows at the very next strobe as a command out of order, an extra command or a missing one. A wrong skip decision drops or adds a mode-register write in the rewrite phase. A miscounting wait counter shifts the cycle of the first strobe after that wait, so it is seen within one wait length. A bad capture or mask shows as wrong data on the first mode-register write that uses it.

// File: rtl/reclk_pkg.sv
package reclk_pkg;

  typedef enum logic [1:0] {
    MK_DDR2  = 2'd0,
    MK_DDR3  = 2'd1,
    MK_GDDR3 = 2'd2,
    MK_NONE  = 2'd3
  } mem_kind_e;

  localparam int NCMD    = 7;
  localparam int CI_PRE  = 0;
  localparam int CI_REF  = 1;
  localparam int CI_MRS  = 2;
  localparam int CI_AOFF = 3;
  localparam int CI_AON  = 4;
  localparam int CI_SON  = 5;
  localparam int CI_SOFF = 6;

  localparam int DLL_RST_BIT = 8;

  typedef enum logic [4:0] {
    S_IDLE, S_LOAD,
    S_DOFF_PRE, S_DOFF_MRS,
    S_SR_PRE, S_SR_REF1, S_SR_REF2, S_SR_AOFF, S_SR_SON,
    S_CLK,
    S_EX_PRE, S_EX_SOFF, S_EX_AON,
    S_MR2, S_MR1, S_MR0,
    S_TIM,
    S_DR_SET, S_DR_CLR, S_DR_PRE,
    S_DONE, S_WAIT
  } step_e;

  function automatic logic kind_ok(logic [1:0] k);
    return k != MK_NONE;
  endfunction

  function automatic int dll_off_pos(logic [1:0] k);
    return (k == MK_GDDR3) ? 6 : 0;
  endfunction

  function automatic int lock_pick(logic [1:0] k, int t_ddr2, int t_ddr3, int t_gddr3);
    case (k)
      MK_DDR3:  return t_ddr3;
      MK_GDDR3: return t_gddr3;
      default:  return t_ddr2;
    endcase
  endfunction

endpackage

// File: rtl/reclk_wait.sv
module reclk_wait #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R13: a running wait loses exactly one count per cycle
  p_wait_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/reclk_plan.sv
module reclk_plan
  import reclk_pkg::*;
#(
  parameter int MR_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [1:0]      kind_i,
  input  logic [MR_W-1:0] cur0_i,
  input  logic [MR_W-1:0] cur1_i,
  input  logic [MR_W-1:0] cur2_i,
  input  logic [MR_W-1:0] tgt0_i,
  input  logic [MR_W-1:0] tgt1_i,
  input  logic [MR_W-1:0] tgt2_i,
  output logic [1:0]      kind_o,
  output logic            doff_o,
  output logic [2:0]      wr_o,
  output logic            dll_rst_o,
  output logic [MR_W-1:0] doff_data_o,
  output logic [MR_W-1:0] tgt0_o,
  output logic [MR_W-1:0] tgt1_o,
  output logic [MR_W-1:0] tgt2_o
);

  logic [1:0]      kind_q;
  logic [MR_W-1:0] cur_q [3];
  logic [MR_W-1:0] tgt_q [3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= MK_DDR2;
      for (int i = 0; i < 3; i++) begin
        cur_q[i] <= '0;
        tgt_q[i] <= '0;
      end
    end else if (load_i) begin
      kind_q   <= kind_i;
      cur_q[0] <= cur0_i;
      cur_q[1] <= cur1_i;
      cur_q[2] <= cur2_i;
      tgt_q[0] <= tgt0_i;
      tgt_q[1] <= tgt1_i;
      tgt_q[2] <= tgt2_i;
    end
  end

  logic [MR_W-1:0] mask;
  logic [MR_W-1:0] cur2_eff;

  always_comb begin
    mask        = MR_W'(1) << dll_off_pos(kind_q);
    cur2_eff    = (kind_q == MK_DDR3) ? cur_q[2] : tgt_q[2];
    doff_o      = ((cur_q[1] & mask) == '0) && ((tgt_q[1] & mask) != '0);
    wr_o[2]     = (cur2_eff != tgt_q[2]);
    wr_o[1]     = (cur_q[1] != tgt_q[1]);
    wr_o[0]     = (cur_q[0] != tgt_q[0]);
    dll_rst_o   = ((tgt_q[1] & mask) == '0);
    doff_data_o = cur_q[1] | mask;
  end

  assign kind_o = kind_q;
  assign tgt0_o = tgt_q[0];
  assign tgt1_o = tgt_q[1];
  assign tgt2_o = tgt_q[2];

endmodule

// File: rtl/dram_reclock_seq.sv
module dram_reclock_seq
  import reclk_pkg::*;
#(
  parameter int MR_W         = 16,
  parameter int T_MRD        = 1000,
  parameter int T_CKSRE      = 0,
  parameter int T_CKSRX      = 0,
  parameter int T_XS         = 0,
  parameter int T_DLLK_DDR2  = 2000,
  parameter int T_DLLK_DDR3  = 12000,
  parameter int T_DLLK_GDDR3 = 40000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      kind_i,
  input  logic [MR_W-1:0] cur_mr0_i,
  input  logic [MR_W-1:0] cur_mr1_i,
  input  logic [MR_W-1:0] cur_mr2_i,
  input  logic [MR_W-1:0] tgt_mr0_i,
  input  logic [MR_W-1:0] tgt_mr1_i,
  input  logic [MR_W-1:0] tgt_mr2_i,
  input  logic            clk_ack_i,
  input  logic            tim_ack_i,
  output logic [NCMD-1:0] cmd_o,
  output logic [1:0]      mrs_idx_o,
  output logic [MR_W-1:0] mrs_data_o,
  output logic            clk_req_o,
  output logic            tim_req_o,
  output logic            done_o,
  output logic            err_o
);

  localparam int LK_A   = (T_DLLK_DDR2 > T_DLLK_DDR3) ? T_DLLK_DDR2 : T_DLLK_DDR3;
  localparam int LK_MAX = (LK_A > T_DLLK_GDDR3) ? LK_A : T_DLLK_GDDR3;
  localparam int W_SUM  = T_MRD + LK_MAX + T_CKSRE + T_CKSRX + T_XS;
  localparam int CW     = $clog2(W_SUM + 2);

  step_e st_q, st_d, ret_q, ret_d, nat, succ;
  logic  err_q;

  // named internal events
  logic            load_plan;
  logic            adv;
  logic            wait_ld;
  logic [CW-1:0]   wait_val;
  logic [CW-1:0]   wv;
  logic            wait_done;

  logic [1:0]      kind_q;
  logic            doff, dll_rst;
  logic [2:0]      wr;
  logic [MR_W-1:0] doff_data, tgt0, tgt1, tgt2;

  function automatic logic [CW-1:0] wait_of(step_e s, logic [1:0] k);
    case (s)
      S_DOFF_MRS, S_MR2, S_MR1, S_MR0, S_DR_SET: return CW'(T_MRD);
      S_SR_SON: return CW'(T_CKSRE);
      S_CLK:    return CW'(T_CKSRX);
      S_EX_AON: return CW'(T_XS);
      S_DR_CLR: return CW'(T_MRD + lock_pick(k, T_DLLK_DDR2, T_DLLK_DDR3, T_DLLK_GDDR3));
      default:  return '0;
    endcase
  endfunction

  assign load_plan = (st_q == S_IDLE) && start_i && kind_ok(kind_i);

  reclk_plan #(.MR_W(MR_W)) u_plan (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_plan),
    .kind_i      (kind_i),
    .cur0_i      (cur_mr0_i),
    .cur1_i      (cur_mr1_i),
    .cur2_i      (cur_mr2_i),
    .tgt0_i      (tgt_mr0_i),
    .tgt1_i      (tgt_mr1_i),
    .tgt2_i      (tgt_mr2_i),
    .kind_o      (kind_q),
    .doff_o      (doff),
    .wr_o        (wr),
    .dll_rst_o   (dll_rst),
    .doff_data_o (doff_data),
    .tgt0_o      (tgt0),
    .tgt1_o      (tgt1),
    .tgt2_o      (tgt2)
  );

  reclk_wait #(.CW(CW)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (wait_ld),
    .val_i     (wait_val),
    .expired_o (wait_done)
  );

  // natural successor, then skip the conditional steps that are not needed
  always_comb begin
    case (st_q)
      S_LOAD:     nat = S_DOFF_PRE;
      S_DOFF_PRE: nat = S_DOFF_MRS;
      S_DOFF_MRS: nat = S_SR_PRE;
      S_SR_PRE:   nat = S_SR_REF1;
      S_SR_REF1:  nat = S_SR_REF2;
      S_SR_REF2:  nat = S_SR_AOFF;
      S_SR_AOFF:  nat = S_SR_SON;
      S_SR_SON:   nat = S_CLK;
      S_CLK:      nat = S_EX_PRE;
      S_EX_PRE:   nat = S_EX_SOFF;
      S_EX_SOFF:  nat = S_EX_AON;
      S_EX_AON:   nat = S_MR2;
      S_MR2:      nat = S_MR1;
      S_MR1:      nat = S_MR0;
      S_MR0:      nat = S_TIM;
      S_TIM:      nat = S_DR_SET;
      S_DR_SET:   nat = S_DR_CLR;
      S_DR_CLR:   nat = S_DR_PRE;
      default:    nat = S_DONE;
    endcase
    succ = nat;
    if (succ == S_DOFF_PRE && !doff)               succ = S_SR_PRE;
    if (succ == S_MR2 && !wr[2])                   succ = S_MR1;
    if (succ == S_MR1 && !wr[1])                   succ = S_MR0;
    if (succ == S_MR0 && !wr[0])                   succ = S_TIM;
    if (succ == S_DR_SET && !dll_rst)              succ = S_DONE;
    if (succ == S_DR_PRE && kind_q != MK_GDDR3)    succ = S_DONE;
  end

  always_comb begin
    st_d     = st_q;
    ret_d    = ret_q;
    wait_ld  = 1'b0;
    wait_val = '0;
    wv       = wait_of(st_q, kind_q);
    adv      = 1'b0;
    case (st_q)
      S_IDLE: if (load_plan) st_d = S_LOAD;
      S_WAIT: if (wait_done) st_d = ret_q;
      S_DONE: st_d = S_IDLE;
      S_CLK:  adv = clk_ack_i;
      S_TIM:  adv = tim_ack_i;
      default: adv = 1'b1;
    endcase
    if (adv) begin
      if (wv == '0) begin
        st_d = succ;
      end else begin
        wait_ld  = 1'b1;
        wait_val = wv - 1'b1;
        st_d     = S_WAIT;
        ret_d    = succ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      ret_q <= S_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ret_q <= ret_d;
      err_q <= (st_q == S_IDLE) && start_i && !kind_ok(kind_i);
    end
  end

  always_comb begin
    cmd_o      = '0;
    mrs_idx_o  = 2'd0;
    mrs_data_o = '0;
    case (st_q)
      S_DOFF_PRE, S_SR_PRE, S_EX_PRE, S_DR_PRE: cmd_o[CI_PRE] = 1'b1;
      S_SR_REF1, S_SR_REF2: cmd_o[CI_REF]  = 1'b1;
      S_SR_AOFF:            cmd_o[CI_AOFF] = 1'b1;
      S_SR_SON:             cmd_o[CI_SON]  = 1'b1;
      S_EX_SOFF:            cmd_o[CI_SOFF] = 1'b1;
      S_EX_AON:             cmd_o[CI_AON]  = 1'b1;
      S_DOFF_MRS: begin cmd_o[CI_MRS] = 1'b1; mrs_idx_o = 2'd1; mrs_data_o = doff_data; end
      S_MR2:      begin cmd_o[CI_MRS] = 1'b1; mrs_idx_o = 2'd2; mrs_data_o = tgt2; end
      S_MR1:      begin cmd_o[CI_MRS] = 1'b1; mrs_idx_o = 2'd1; mrs_data_o = tgt1; end
      S_MR0:      begin cmd_o[CI_MRS] = 1'b1; mrs_idx_o = 2'd0; mrs_data_o = tgt0; end
      S_DR_SET: begin
        cmd_o[CI_MRS] = 1'b1;
        mrs_data_o    = tgt0 | (MR_W'(1) << DLL_RST_BIT);
      end
      S_DR_CLR:   begin cmd_o[CI_MRS] = 1'b1; mrs_data_o = tgt0; end
      default: ;
    endcase
  end

  assign clk_req_o = (st_q == S_CLK);
  assign tim_req_o = (st_q == S_TIM);
  assign done_o    = (st_q == S_DONE);
  assign err_o     = err_q;

  // R14: never two strobes or requests at once
  p_onehot_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_o, clk_req_o, tim_req_o, done_o, err_o}));

  // R2: an error pulse is not followed by any device activity
  p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (cmd_o == '0 && !clk_req_o && !tim_req_o));

  // R5: clock-change request holds until acknowledged
  p_clk_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_req_o && !clk_ack_i) |=> clk_req_o);

  // R8: timing-update request holds until acknowledged
  p_tim_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tim_req_o && !tim_ack_i) |=> tim_req_o);

  // R6: only registers 0..2 are ever written
  p_mr_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o[CI_MRS] |-> (mrs_idx_o != 2'd3));

  // R7: MR2 writes only happen for DDR3
  p_mr2_ddr3_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o[CI_MRS] && mrs_idx_o == 2'd2) |-> (kind_q == MK_DDR3));

  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12: a start while busy never restarts the sequence
  p_start_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE && start_i) |=> (st_q != S_LOAD));

endmodule

// File: tb/dram_reclock_seq_tb.sv
`timescale 1ns/1ps
module dram_reclock_seq_tb;

  localparam int MW = 16;
  localparam int MRD = 3, CKSRE = 0, CKSRX = 2, XS = 4;
  localparam int LK2 = 5, LK3 = 9, LKG = 13;
  localparam int LAT = 3;

  // {kind[1:0], mrs writes[3:0], c0, c1, c2, t0, t1, t2}
  localparam logic [101:0] VEC [8] = '{
    {2'd0, 4'd2, 16'h0432, 16'h0000, 16'h0000, 16'h0432, 16'h0000, 16'h0000},
    {2'd1, 4'd4, 16'h1000, 16'h0004, 16'h0008, 16'h1200, 16'h0004, 16'h0010},
    {2'd1, 4'd2, 16'h0010, 16'h0000, 16'h0000, 16'h0010, 16'h0001, 16'h0000},
    {2'd2, 4'd3, 16'h0020, 16'h0000, 16'h0005, 16'h0021, 16'h0040, 16'h0005},
    {2'd2, 4'd3, 16'h0100, 16'h0001, 16'h0000, 16'h0100, 16'h0003, 16'h0007},
    {2'd0, 4'd1, 16'h0010, 16'h0001, 16'h0003, 16'h0011, 16'h0001, 16'h0009},
    {2'd1, 4'd3, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {2'd0, 4'd4, 16'h0001, 16'h0004, 16'h0000, 16'h0002, 16'h0008, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] kind_i = 2'd0;
  logic [MW-1:0] c0 = '0, c1 = '0, c2 = '0, t0 = '0, t1 = '0, t2 = '0;
  logic clk_ack_i = 1'b0, tim_ack_i = 1'b0;
  logic [6:0] cmd_o;
  logic [1:0] mrs_idx_o;
  logic [MW-1:0] mrs_data_o;
  logic clk_req_o, tim_req_o, done_o, err_o;

  always #2 clk = ~clk;

  dram_reclock_seq #(
    .MR_W(MW), .T_MRD(MRD), .T_CKSRE(CKSRE), .T_CKSRX(CKSRX), .T_XS(XS),
    .T_DLLK_DDR2(LK2), .T_DLLK_DDR3(LK3), .T_DLLK_GDDR3(LKG)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
    .cur_mr0_i(c0), .cur_mr1_i(c1), .cur_mr2_i(c2),
    .tgt_mr0_i(t0), .tgt_mr1_i(t1), .tgt_mr2_i(t2),
    .clk_ack_i(clk_ack_i), .tim_ack_i(tim_ack_i),
    .cmd_o(cmd_o), .mrs_idx_o(mrs_idx_o), .mrs_data_o(mrs_data_o),
    .clk_req_o(clk_req_o), .tim_req_o(tim_req_o), .done_o(done_o), .err_o(err_o)
  );

  int nchk = 0, nfail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // observed events: kind 0..6 strobes, 7 clock req, 8 timing req, 9 done, 10 error
  int on = 0, multi = 0;
  int okind [64], oidx [64], odata [64], ocyc [64];
  bit seen_end = 0, clk_prev = 0, tim_prev = 0;
  int hc_c = 0, hc_t = 0;

  task automatic rec(int k, int ix, int d);
    if (on < 64) begin
      okind[on] = k; oidx[on] = ix; odata[on] = d; ocyc[on] = cyc;
    end
    on++;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_o != '0) begin
        if ($countones(cmd_o) > 1) multi++;
        for (int b = 6; b >= 0; b--)
          if (cmd_o[b]) begin
            rec(b, (b == 2) ? int'(mrs_idx_o) : 0, (b == 2) ? int'(mrs_data_o) : 0);
            break;
          end
      end
      if (clk_req_o && !clk_prev) rec(7, 0, 0);
      if (tim_req_o && !tim_prev) rec(8, 0, 0);
      if (done_o) begin rec(9, 0, 0); seen_end = 1; end
      if (err_o)  begin rec(10, 0, 0); seen_end = 1; end
    end
    clk_prev = clk_req_o;
    tim_prev = tim_req_o;
    if (clk_req_o) hc_c++; else hc_c = 0;
    if (tim_req_o) hc_t++; else hc_t = 0;
    clk_ack_i = clk_req_o && (hc_c == LAT);
    tim_ack_i = tim_req_o && (hc_t == LAT);
  end

  // expected model
  int en = 0, g = 0;
  int ekind [64], eidx [64], edata [64], egap [64];
  string ereq [64];

  task automatic push(int k, int ix, int d, string tag);
    ekind[en] = k; eidx[en] = ix; edata[en] = d; egap[en] = g; ereq[en] = tag;
    en++;
    g = (k == 7 || k == 8) ? LAT : 1;
  endtask

  task automatic build(int kind, int a0, int a1, int a2, int b0, int b1, int b2);
    int m, lk;
    en = 0; g = 1;
    if (kind == 3) begin g = 0; push(10, 0, 0, "R2"); return; end
    m  = (kind == 2) ? 'h40 : 'h1;
    lk = (kind == 0) ? LK2 : (kind == 1) ? LK3 : LKG;
    if (((a1 & m) == 0) && ((b1 & m) != 0)) begin
      push(0, 0, 0, "R3"); push(2, 1, a1 | m, "R3"); g += MRD;
    end
    push(0, 0, 0, "R4"); push(1, 0, 0, "R4"); push(1, 0, 0, "R4");
    push(3, 0, 0, "R4"); push(5, 0, 0, "R4"); g += CKSRE;
    push(7, 0, 0, "R4"); g += CKSRX;
    push(0, 0, 0, "R5"); push(6, 0, 0, "R5"); push(4, 0, 0, "R5"); g += XS;
    if (kind == 1 && a2 != b2) begin push(2, 2, b2, "R6"); g += MRD; end
    if (a1 != b1) begin push(2, 1, b1, "R6"); g += MRD; end
    if (a0 != b0) begin push(2, 0, b0, "R6"); g += MRD; end
    push(8, 0, 0, "R8");
    if ((b1 & m) == 0) begin
      push(2, 0, b0 | 'h100, "R9"); g += MRD;
      push(2, 0, b0, "R9"); g += MRD + lk;
      if (kind == 2) push(0, 0, 0, "R10");
    end
    push(9, 0, 0, "R11");
  endtask

  task automatic run(int kind, int a0, int a1, int a2, int b0, int b1, int b2,
                     bit inject, int nmrs, string cnt_tag, string over);
    int st, prev, nm;
    build(kind, a0, a1, a2, b0, b1, b2);
    @(negedge clk);
    kind_i = kind[1:0]; c0 = a0[15:0]; c1 = a1[15:0]; c2 = a2[15:0];
    t0 = b0[15:0]; t1 = b1[15:0]; t2 = b2[15:0];
    on = 0; seen_end = 0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; st = cyc;
    if (inject) begin
      repeat (6) @(negedge clk);
      kind_i = 2'd3; c0 = '1; c1 = '1; c2 = '1; t0 = '1; t1 = '1; t2 = '1;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int w = 0; w < 3000 && !seen_end; w++) @(negedge clk);
    repeat (8) @(negedge clk);
    check(on == en, (over != "") ? over : cnt_tag, on, en);
    prev = st; nm = 0;
    for (int i = 0; i < on && i < en && i < 64; i++) begin
      check(okind[i] == ekind[i] && oidx[i] == eidx[i] && odata[i] == edata[i],
            (over != "") ? over : ereq[i],
            (okind[i] << 20) | (oidx[i] << 16) | odata[i],
            (ekind[i] << 20) | (eidx[i] << 16) | edata[i]);
      check(ocyc[i] - prev == egap[i], (over != "") ? over : "R13", ocyc[i] - prev, egap[i]);
      prev = ocyc[i];
    end
    for (int i = 0; i < on && i < 64; i++) if (okind[i] == 2) nm++;
    if (nmrs >= 0) check(nm == nmrs, cnt_tag, nm, nmrs);
  endtask

  bit finished = 0;

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(cmd_o == '0 && !clk_req_o && !tim_req_o && !done_o && !err_o, "R1",
          {cmd_o, clk_req_o, tim_req_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cmd_o == '0 && !clk_req_o && !tim_req_o && !done_o && !err_o, "R1",
          {cmd_o, clk_req_o, tim_req_o, done_o, err_o}, 0);

    // vector table walk (R3..R11, R13)
    for (int v = 0; v < 8; v++) begin
      run(int'(VEC[v][101:100]), int'(VEC[v][95:80]), int'(VEC[v][79:64]), int'(VEC[v][63:48]),
          int'(VEC[v][47:32]), int'(VEC[v][31:16]), int'(VEC[v][15:0]),
          1'b0, int'(VEC[v][99:96]), (v == 4 || v == 5) ? "R7" : "R6", "");
    end

    // R2: unsupported kind gives an error pulse and nothing else
    run(3, 'h1, 'h2, 'h3, 'h4, 'h5, 'h6, 1'b0, 0, "R2", "");
    check(on == 1 && okind[0] == 10, "R2", on, 1);

    // R12: start and input changes while busy are ignored
    run(1, 'h1000, 'h0004, 'h0008, 'h1200, 'h0004, 'h0010, 1'b1, 4, "R12", "R12");

    // R14: strobes never overlap
    check(multi == 0, "R14", multi, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule